// File: doc/BRIEF.md
# Contended Lock Limiter Tracker

This block sits beside a memory request scheduler and decides, once per interval, which hardware thread is most likely holding up the rest of a parallel program. Every cycle each thread says whether it is stalled on a lock and which lock slot it is stalled on. The block keeps one wait-cycle total per lock slot, summed over all threads stalled on that slot. When the interval closes, the slot with the largest total is taken as the most contended lock.

The block also keeps a holder table that it fills from separate acquire and release event ports. It looks up the thread that owns the most contended lock and presents that thread as a one-hot limiter mask. The scheduler uses the mask to favour the limiter's memory requests. The interval length is an input, so the scheduler can retune it at run time. The totals restart from zero at every interval boundary.

Top module: `lock_limiter_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, the limiter mask is zero, every lock slot has no holder and every wait total is zero.
- R2: Interval boundaries fall on cycles interval_len-1, 2*interval_len-1, and so on, counted from the first clock edge after reset is released (a length of 0 behaves as 1). The limiter mask takes its new value on the clock edge that ends a boundary cycle, so it becomes visible in the following cycle, and it holds that value at all other times.
- R3: In every cycle, each lock slot's total grows by the number of threads whose wait_vld bit is 1 and whose 3-bit lock field (thread t at wait_lock bits [3t+2:3t]) equals that slot. A thread whose wait_vld bit is 0 adds nothing, whatever its lock field holds.
- R4: Each wait total saturates at 2^CNT_W-1 and never wraps.
- R5: Waits in the boundary cycle count toward the interval that is closing. All totals are zero at the start of the next interval.
- R6: The most contended lock is the slot with the largest closing total. When totals are equal, the lowest slot index wins.
- R7: When every closing total is zero, the new limiter mask is zero.
- R8: An acquire event records acq_thread as the holder of acq_lock, and a release event marks rel_lock as free. When both target the same slot in one cycle, the release is applied first, so the acquirer becomes the holder.
- R9: Acquire and release events in the boundary cycle are applied before the holder of the winning lock is looked up.
- R10: The new limiter mask has bit h set and no other bit, where h is the holder of the winning lock. It is zero when the winning lock has no holder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_len | input | IVL_W | Interval length in cycles |
| wait_vld | input | NT | Per-thread waiting flag |
| wait_lock | input | NT*3 | Per-thread lock slot being waited on, 3 bits per thread |
| acq_vld | input | 1 | Acquire event valid |
| acq_lock | input | 3 | Lock slot acquired |
| acq_thread | input | 4 | Thread that acquired the lock |
| rel_vld | input | 1 | Release event valid |
| rel_lock | input | 3 | Lock slot released |
| limiter_mask | output | NT | One-hot limiter thread, or zero |

## Verification
The assertions assume that an acquire only targets a lock slot that is free, or that is released in the same cycle. The holder checks depend on this, because a second acquire would silently overwrite the owner. The stimulus keeps to this rule. Each scenario starts from reset, acquires each slot at most once, and hands a lock to a new owner only through a same-cycle release and acquire. It also keeps interval_len constant within a scenario, so the boundary positions the bench predicts do not move under the design.

// File: rtl/lt_pkg.sv
package lt_pkg;
    localparam int LT_THREADS = 16;
    localparam int LT_LOCKS   = 8;
    localparam int LT_CNT_W   = 24;
    localparam int LT_IVL_W   = 16;
endpackage

// File: rtl/lt_wait_accum.sv
module lt_wait_accum
    import lt_pkg::*;
#(
    parameter int NT    = LT_THREADS,
    parameter int NL    = LT_LOCKS,
    parameter int CNT_W = LT_CNT_W,
    localparam int LW   = $clog2(NL)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [NT-1:0]        wait_vld,
    input  logic [NT*LW-1:0]     wait_lock,
    output logic [NL*CNT_W-1:0]  closing_tot
);
    localparam int HW = $clog2(NT + 1);
    localparam logic [CNT_W-1:0] SAT = '1;

    typedef struct packed {
        logic [NL-1:0][CNT_W-1:0] acc;
    } acc_st_t;

    acc_st_t s_d, s_q;
    logic [NL-1:0][CNT_W-1:0] tot_c;

    always_comb begin
        logic [HW-1:0]  hits;
        logic [CNT_W:0] sum;
        tot_c = '0;
        for (int l = 0; l < NL; l++) begin
            hits = '0;
            for (int t = 0; t < NT; t++) begin
                if (wait_vld[t] && (wait_lock[t*LW +: LW] == LW'(l)))
                    hits = hits + HW'(1);
            end
            sum = {1'b0, s_q.acc[l]} + (CNT_W+1)'(hits);
            tot_c[l] = sum[CNT_W] ? SAT : sum[CNT_W-1:0];
        end
        s_d.acc = clear ? '0 : tot_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign closing_tot = tot_c;

    for (genvar g = 0; g < NL; g++) begin : g_chk
        // R4
        acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> s_q.acc[g] >= $past(s_q.acc[g]));
        // R5
        acc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> s_q.acc[g] == '0);
    end
endmodule

// File: rtl/lt_holder_table.sv
module lt_holder_table
    import lt_pkg::*;
#(
    parameter int NT  = LT_THREADS,
    parameter int NL  = LT_LOCKS,
    localparam int LW = $clog2(NL),
    localparam int TW = $clog2(NT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_vld,
    input  logic [LW-1:0]     acq_lock,
    input  logic [TW-1:0]     acq_thread,
    input  logic              rel_vld,
    input  logic [LW-1:0]     rel_lock,
    output logic [NL-1:0]     own_vld_nx,
    output logic [NL*TW-1:0]  own_id_nx
);
    typedef struct packed {
        logic [NL-1:0]         vld;
        logic [NL-1:0][TW-1:0] id;
    } own_st_t;

    own_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rel_vld) s_d.vld[rel_lock] = 1'b0;
        if (acq_vld) begin
            s_d.vld[acq_lock] = 1'b1;
            s_d.id[acq_lock]  = acq_thread;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign own_vld_nx = s_d.vld;
    assign own_id_nx  = s_d.id;

    // R8
    acq_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_vld |=> s_q.vld[$past(acq_lock)] && (s_q.id[$past(acq_lock)] == $past(acq_thread)));
    // R8
    rel_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_vld && !(acq_vld && acq_lock == rel_lock)) |=> !s_q.vld[$past(rel_lock)]);
    // R8
    acq_on_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_vld |-> (!s_q.vld[acq_lock] || (rel_vld && rel_lock == acq_lock)));
endmodule

// File: rtl/lt_argmax.sv
module lt_argmax
    import lt_pkg::*;
#(
    parameter int NL    = LT_LOCKS,
    parameter int CNT_W = LT_CNT_W,
    localparam int LW   = $clog2(NL)
) (
    input  logic [NL*CNT_W-1:0] totals,
    output logic [LW-1:0]       win_idx,
    output logic                win_any
);
    always_comb begin
        logic [CNT_W-1:0] best;
        best    = totals[0 +: CNT_W];
        win_idx = '0;
        for (int i = 1; i < NL; i++) begin
            if (totals[i*CNT_W +: CNT_W] > best) begin
                best    = totals[i*CNT_W +: CNT_W];
                win_idx = LW'(i);
            end
        end
        win_any = (best != '0);
    end
endmodule

// File: rtl/lock_limiter_tracker.sv
module lock_limiter_tracker
    import lt_pkg::*;
#(
    parameter int NT    = LT_THREADS,
    parameter int NL    = LT_LOCKS,
    parameter int CNT_W = LT_CNT_W,
    parameter int IVL_W = LT_IVL_W,
    localparam int LW   = $clog2(NL),
    localparam int TW   = $clog2(NT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IVL_W-1:0]  interval_len,
    input  logic [NT-1:0]     wait_vld,
    input  logic [NT*LW-1:0]  wait_lock,
    input  logic              acq_vld,
    input  logic [LW-1:0]     acq_lock,
    input  logic [TW-1:0]     acq_thread,
    input  logic              rel_vld,
    input  logic [LW-1:0]     rel_lock,
    output logic [NT-1:0]     limiter_mask
);
    typedef struct packed {
        logic [IVL_W-1:0] cnt;
        logic [NT-1:0]    mask;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [IVL_W-1:0]    len_eff;
    logic                boundary;
    logic [NL*CNT_W-1:0] closing_tot;
    logic [NL-1:0]       own_vld_nx;
    logic [NL*TW-1:0]    own_id_nx;
    logic [LW-1:0]       win_idx;
    logic                win_any;

    assign len_eff  = (interval_len == '0) ? IVL_W'(1) : interval_len;
    assign boundary = (s_q.cnt >= len_eff - IVL_W'(1));

    lt_wait_accum #(.NT(NT), .NL(NL), .CNT_W(CNT_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (boundary),
        .wait_vld    (wait_vld),
        .wait_lock   (wait_lock),
        .closing_tot (closing_tot)
    );

    lt_holder_table #(.NT(NT), .NL(NL)) u_owner (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_vld    (acq_vld),
        .acq_lock   (acq_lock),
        .acq_thread (acq_thread),
        .rel_vld    (rel_vld),
        .rel_lock   (rel_lock),
        .own_vld_nx (own_vld_nx),
        .own_id_nx  (own_id_nx)
    );

    lt_argmax #(.NL(NL), .CNT_W(CNT_W)) u_pick (
        .totals  (closing_tot),
        .win_idx (win_idx),
        .win_any (win_any)
    );

    always_comb begin
        s_d     = s_q;
        s_d.cnt = boundary ? '0 : s_q.cnt + IVL_W'(1);
        if (boundary) begin
            s_d.mask = '0;
            if (win_any && own_vld_nx[win_idx])
                s_d.mask[own_id_nx[win_idx*TW +: TW]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign limiter_mask = s_q.mask;

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(limiter_mask));
    // R10
    mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(limiter_mask));
    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !win_any) |=> limiter_mask == '0);
endmodule

// File: tb/sim_lock_limiter_tracker.sv
module sim_lock_limiter_tracker;
    localparam int NT = 16;
    localparam int NL = 8;
    localparam int LW = 3;
    localparam int TW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        ilen = 8'd8;
    logic [NT-1:0]     wv = '0;
    logic [NT*LW-1:0]  wl = '0;
    logic              av = 1'b0;
    logic [LW-1:0]     al = '0;
    logic [TW-1:0]     at = '0;
    logic              rv = 1'b0;
    logic [LW-1:0]     rl = '0;
    logic [NT-1:0]     mask;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lock_limiter_tracker #(.NT(NT), .NL(NL), .CNT_W(6), .IVL_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .interval_len(ilen),
        .wait_vld(wv), .wait_lock(wl),
        .acq_vld(av), .acq_lock(al), .acq_thread(at),
        .rel_vld(rv), .rel_lock(rl),
        .limiter_mask(mask)
    );

    task automatic check(input string req, input logic [NT-1:0] exp);
        checks++;
        if (mask !== exp) begin
            errors++;
            $display("FAIL %s: limiter_mask actual %h expected %h", req, mask, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic no_events();
        av = 1'b0; rv = 1'b0;
    endtask

    task automatic acquire(input int l, input int t);
        av = 1'b1; al = LW'(l); at = TW'(t);
    endtask

    task automatic set_wait(input int t, input int l);
        wv[t] = 1'b1; wl[t*LW +: LW] = LW'(l);
    endtask

    task automatic restart(input int len);
        @(negedge clk);
        rst_n = 1'b0; ilen = 8'(len);
        wv = '0; wl = '0; no_events();
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick(2);
        check("R1 during reset", '0);
        rst_n = 1'b1;
        tick(1);
        check("R1 after reset", '0);
    endtask

    task automatic t_basic();
        restart(8);
        acquire(2, 5); tick();
        acquire(4, 9); tick();
        no_events();
        set_wait(0, 2); set_wait(1, 2); set_wait(3, 4);
        tick(5);
        check("R2 no update before boundary", '0);
        tick();
        check("R6 R10 largest total holder", 16'h0020);
        wv = '0;
        tick(7);
        check("R2 mask held inside interval", 16'h0020);
        tick();
        check("R7 idle interval gives zero", '0);
    endtask

    task automatic t_tie_ignored();
        restart(6);
        acquire(1, 2); tick();
        acquire(6, 11); tick();
        acquire(7, 10); tick();
        no_events();
        set_wait(4, 1); set_wait(6, 6);
        for (int t = 8; t < 16; t++) wl[t*LW +: LW] = 3'd7;
        tick(3);
        check("R6 tie lowest slot, R3 unflagged ignored", 16'h0004);
    endtask

    task automatic t_sum_threads();
        restart(6);
        acquire(1, 2); tick();
        acquire(2, 13); tick();
        no_events();
        set_wait(0, 1); set_wait(1, 1); set_wait(3, 1); set_wait(4, 2);
        tick(2);
        wv[0] = 1'b0; wv[1] = 1'b0; wv[3] = 1'b0;
        tick(2);
        check("R3 totals sum over threads", 16'h0004);
    endtask

    task automatic t_release_at_edge();
        restart(6);
        acquire(3, 7); tick();
        no_events();
        set_wait(0, 3);
        tick(4);
        rv = 1'b1; rl = 3'd3;
        tick();
        no_events();
        check("R9 R10 release at boundary leaves no holder", '0);
    endtask

    task automatic t_handoff();
        restart(6);
        acquire(3, 7); tick();
        no_events();
        set_wait(0, 3);
        tick(4);
        rv = 1'b1; rl = 3'd3; acquire(3, 12);
        tick();
        no_events();
        check("R8 R9 handoff at boundary", 16'h1000);
        tick(6);
        check("R8 holder persists into next interval", 16'h1000);
        restart(6);
        set_wait(0, 3);
        tick(6);
        check("R1 reset frees holders", '0);
    endtask

    task automatic t_saturate();
        restart(40);
        acquire(0, 3); tick();
        acquire(5, 15);
        for (int t = 8; t < 15; t++) set_wait(t, 5);
        tick();
        no_events();
        for (int t = 0; t < 7; t++) set_wait(t, 0);
        tick(37);
        check("R2 no update before long boundary", '0);
        tick();
        check("R4 saturated totals tie to lowest slot", 16'h0008);
        wv = '0;
        set_wait(8, 5);
        tick();
        wv = '0;
        tick(39);
        check("R5 totals cleared at boundary", 16'h8000);
    endtask

    task automatic t_edge_waits();
        restart(5);
        acquire(6, 1); tick();
        acquire(2, 8);
        set_wait(9, 2);
        tick();
        no_events();
        tick(2);
        wv = '0;
        for (int t = 0; t < 5; t++) set_wait(t, 6);
        tick();
        check("R5 boundary-cycle waits count", 16'h0002);
        wv = '0;
        tick(5);
        check("R5 R7 nothing carried over", '0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_basic();
                t_tie_ignored();
                t_sum_threads();
                t_release_at_edge();
                t_handoff();
                t_saturate();
                t_edge_waits();
            end
            begin
                #(200000 * 8);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule